// File: doc/BRIEF.md
# Vector Duplicate Count and Uniquify Unit

This unit takes one vector of lane values together with a per-lane enable mask and an instruction word. The opcode field of that word picks one of two operations, each in an integer or a float flavour. A count operation reports, for each lane, how many enabled lanes carry the same value. A uniquify operation packs the distinct values into the low slots of a vector. Both operations always produce the same three outputs, registered in one step: a data vector, a map from each slot to the lowest lane that filled it, and a map from each input lane to its slot. The last map is the inverse permutation that a consumer uses to route per-slot results back to every input lane.

A single pairwise equality network feeds all three outputs. Values are compared as raw bit patterns whatever the flavour. The float flavour changes only how a count is encoded in the data vector. A small two-state controller sits at the output. In `S_IDLE` no result is presented. An accepted legal request moves it to `S_RESULT`, where `out_valid` is high for one cycle. From `S_RESULT` it stays there if another request is accepted and returns to `S_IDLE` otherwise. A request with any other opcode is dropped and leaves the controller in `S_IDLE`.

Top module: `dcu_top`

## Requirements
- R1: The opcode is bits 21..16 of `in_instr`. Value 24 is an integer count, 25 a float count, 26 an integer uniquify and 27 a float uniquify. Every other bit of the word is ignored. A request with any other opcode gives no `out_valid` and leaves all outputs unchanged.
- R2: `out_valid` is high exactly in the cycle after a legal request is accepted (`in_valid` high with a legal opcode) and low otherwise. The three result vectors change only on an accepted request.
- R3: For an integer count, lane k of `out_data` is the unsigned number of enabled lanes whose value equals lane k's value, counting lane k itself.
- R4: For a float count, lane k of `out_data` is that same count encoded as an IEEE-754 single-precision number (for example, 3 is 0x40400000), and 0 is encoded as 0x00000000.
- R5: Equality is bit-pattern equality in both flavours. So 0x00000000 and 0x80000000 are different values, and two lanes with the same NaN pattern are equal.
- R6: A lane whose `in_mask` bit is 0 takes part in no comparison. For count operations it reports a data value of 0, and for every operation it reports a slot of 0.
- R7: Slots are numbered in order of first occurrence, scanning from lane 0 upward. Lane k of `out_lane_slot` is the slot number of lane k's value.
- R8: For uniquify, slot s of `out_data` holds the value that was numbered s. Slots at or beyond the number of distinct values read 0.
- R9: Slot s of `out_first_lane` is the lowest enabled lane holding the value numbered s, for both operations. Slots at or beyond the number of distinct values read 0.
- R10: For the same vector and mask, a count and a uniquify produce identical `out_first_lane` and `out_lane_slot`.
- R11: While `rst_n` is low and after its release, `out_valid` is 0 and every result vector is 0 until the first accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_instr | input | 32 | Instruction word; opcode in bits 21..16 |
| in_vec | input | LANES*32 | Lane values, lane k in bits 32k+31..32k |
| in_mask | input | LANES | Lane enables, bit k for lane k |
| out_valid | output | 1 | Result registers hold a fresh result |
| out_data | output | LANES*32 | Counts or packed distinct values |
| out_first_lane | output | LANES*32 | Per slot, lowest lane that produced it |
| out_lane_slot | output | LANES*32 | Per lane, slot it collapsed onto |

## Verification
The case that is hardest to reach from the ports is a vector where masked-off lanes hold copies of enabled values while the enabled lanes repeat out of order. In that case the slot numbering, the first-lane map and the counts all depend on ignoring the hidden copies. The stimulus builds such vectors directly and adds float patterns (signed zeros, matching and differing NaNs). It then runs a long stream of back-to-back requests drawn from a four-value alphabet, with random masks, random opcodes including illegal ones, and junk in the non-opcode bits. A behavioural model built on queues predicts every output on every clock.

// File: rtl/dcu_pkg.sv
package dcu_pkg;

    localparam int WORD_W  = 32;
    localparam int OPC_LSB = 16;
    localparam int OPC_W   = 6;

    typedef enum logic [OPC_W-1:0] {
        OPC_CNT_INT  = 6'd24,
        OPC_CNT_FP   = 6'd25,
        OPC_UNIQ_INT = 6'd26,
        OPC_UNIQ_FP  = 6'd27
    } dcu_opc_e;

    typedef enum logic {
        KIND_COUNT = 1'b0,
        KIND_UNIQ  = 1'b1
    } dcu_kind_e;

    typedef struct packed {
        logic      legal;
        dcu_kind_e kind;
        logic      is_float;
    } dcu_dec_t;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_RESULT = 1'b1
    } dcu_state_e;

    // Unsigned integer to single-precision bit pattern (truncating).
    function automatic logic [WORD_W-1:0] count_to_f32(input logic [WORD_W-1:0] c);
        logic [WORD_W-1:0] norm;
        logic [7:0]        expo;
        int                msb;
        msb = 0;
        for (int i = 0; i < WORD_W; i++) begin
            if (c[i]) msb = i;
        end
        norm = c << (WORD_W - 1 - msb);
        expo = 8'(127 + msb);
        if (c == '0) return '0;
        return {1'b0, expo, norm[WORD_W-2 -: 23]};
    endfunction

endpackage

// File: rtl/dcu_decode.sv
module dcu_decode
    import dcu_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output dcu_dec_t          dec
);
    logic [OPC_W-1:0] opc;
    logic             unused_instr_bits;

    assign opc = instr[OPC_LSB +: OPC_W];
    assign unused_instr_bits = ^{instr[WORD_W-1:OPC_LSB+OPC_W], instr[OPC_LSB-1:0]};

    always_comb begin
        dec = '{legal: 1'b0, kind: KIND_COUNT, is_float: 1'b0};
        case (opc)
            OPC_CNT_INT:  dec = '{legal: 1'b1, kind: KIND_COUNT, is_float: 1'b0};
            OPC_CNT_FP:   dec = '{legal: 1'b1, kind: KIND_COUNT, is_float: 1'b1};
            OPC_UNIQ_INT: dec = '{legal: 1'b1, kind: KIND_UNIQ,  is_float: 1'b0};
            OPC_UNIQ_FP:  dec = '{legal: 1'b1, kind: KIND_UNIQ,  is_float: 1'b1};
            default:      dec = '{legal: 1'b0, kind: KIND_COUNT, is_float: 1'b0};
        endcase
    end
endmodule

// File: rtl/dcu_match_net.sv
module dcu_match_net
    import dcu_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0][WORD_W-1:0] vals,
    input  logic [LANES-1:0]             mask,
    output logic [LANES-1:0][LANES-1:0]  eq
);
    for (genvar k = 0; k < LANES; k++) begin : g_row
        for (genvar j = 0; j < LANES; j++) begin : g_col
            if (k == j) begin : g_self
                assign eq[k][j] = mask[k];
            end else begin : g_pair
                assign eq[k][j] = mask[k] & mask[j] & (vals[k] == vals[j]);
            end
        end
    end
endmodule

// File: rtl/dcu_rank.sv
module dcu_rank
    import dcu_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0][WORD_W-1:0] vals,
    input  logic [LANES-1:0]             mask,
    input  logic [LANES-1:0][LANES-1:0]  eq,
    output logic [LANES-1:0][WORD_W-1:0] cnt,
    output logic [LANES-1:0][WORD_W-1:0] slot,
    output logic [LANES-1:0][WORD_W-1:0] uniq,
    output logic [LANES-1:0][WORD_W-1:0] first_lane
);
    localparam int CW = $clog2(LANES + 1);
    localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0]         is_first;
    logic [LANES-1:0][CW-1:0] pre;
    logic [LANES-1:0][IW-1:0] leader;
    logic [LANES-1:0][CW-1:0] tally;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            tally[k]    = '0;
            is_first[k] = mask[k];
            leader[k]   = '0;
            for (int j = 0; j < LANES; j++) begin
                if (eq[k][j]) tally[k] = tally[k] + CW'(1);
            end
            for (int j = 0; j < k; j++) begin
                if (eq[k][j]) is_first[k] = 1'b0;
            end
            for (int j = LANES - 1; j >= 0; j--) begin
                if (eq[k][j]) leader[k] = IW'(j);
            end
        end
        pre[0] = '0;
        for (int k = 1; k < LANES; k++) begin
            pre[k] = pre[k-1] + CW'(is_first[k-1]);
        end
        for (int k = 0; k < LANES; k++) begin
            cnt[k]  = WORD_W'(tally[k]);
            slot[k] = mask[k] ? WORD_W'(pre[leader[k]]) : '0;
        end
        for (int s = 0; s < LANES; s++) begin
            uniq[s]       = '0;
            first_lane[s] = '0;
            for (int k = 0; k < LANES; k++) begin
                if (is_first[k] && (pre[k] == CW'(s))) begin
                    uniq[s]       = vals[k];
                    first_lane[s] = WORD_W'(k);
                end
            end
        end
    end
endmodule

// File: rtl/dcu_top.sv
module dcu_top
    import dcu_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [31:0]             in_instr,
    input  logic [LANES*32-1:0]     in_vec,
    input  logic [LANES-1:0]        in_mask,
    output logic                    out_valid,
    output logic [LANES*32-1:0]     out_data,
    output logic [LANES*32-1:0]     out_first_lane,
    output logic [LANES*32-1:0]     out_lane_slot
);
    typedef logic [LANES-1:0][WORD_W-1:0] lane_vec_t;

    dcu_dec_t   dec;
    lane_vec_t  vals, cnt, slot, uniq, first_lane, data_d;
    logic [LANES-1:0][LANES-1:0] eq;
    lane_vec_t  data_q, first_q, slot_q;
    dcu_state_e state_q, state_d;
    logic       accept;

    assign vals   = in_vec;
    assign accept = in_valid & dec.legal;

    dcu_decode u_decode (.instr(in_instr), .dec(dec));

    dcu_match_net #(.LANES(LANES)) u_match (
        .vals(vals), .mask(in_mask), .eq(eq)
    );

    dcu_rank #(.LANES(LANES)) u_rank (
        .vals(vals), .mask(in_mask), .eq(eq),
        .cnt(cnt), .slot(slot), .uniq(uniq), .first_lane(first_lane)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_data
        always_comb begin
            if (dec.kind == KIND_UNIQ)  data_d[k] = uniq[k];
            else if (dec.is_float)      data_d[k] = count_to_f32(cnt[k]);
            else                        data_d[k] = cnt[k];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = accept ? S_RESULT : S_IDLE;
            S_RESULT: state_d = accept ? S_RESULT : S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            data_q  <= '0;
            first_q <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                data_q  <= data_d;
                first_q <= first_lane;
                slot_q  <= slot;
            end
        end
    end

    always_comb begin
        out_valid      = (state_q == S_RESULT);
        out_data       = data_q;
        out_first_lane = first_q;
        out_lane_slot  = slot_q;
    end
endmodule

// File: rtl/dcu_checker.sv
module dcu_checker #(
    parameter int LANES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [31:0]         in_instr,
    input logic [LANES-1:0]    in_mask,
    input logic                out_valid,
    input logic [LANES*32-1:0] out_data,
    input logic [LANES*32-1:0] out_first_lane,
    input logic [LANES*32-1:0] out_lane_slot
);
    logic [5:0] opc;
    logic       legal_req;

    assign opc       = in_instr[21:16];
    assign legal_req = in_valid && (opc >= 6'd24) && (opc <= 6'd27);

    p_accept_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        legal_req |=> out_valid);

    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_drop_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legal_req) |=> (!out_valid && $stable(out_data)));

    p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_req |=> ($stable(out_data) && $stable(out_first_lane) && $stable(out_lane_slot)));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        p_masked_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !$past(in_mask[k])) |-> (out_lane_slot[32*k +: 32] == 32'd0));

        p_slot_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_lane_slot[32*k +: 32] < 32'(LANES)));

        if (k > 0) begin : g_order
            p_first_lane_rising_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && (out_first_lane[32*k +: 32] != 32'd0))
                |-> (out_first_lane[32*k +: 32] > out_first_lane[32*(k-1) +: 32]));
        end
    end
endmodule

bind dcu_top dcu_checker #(.LANES(LANES)) u_dcu_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_mask(in_mask), .out_valid(out_valid), .out_data(out_data),
    .out_first_lane(out_first_lane), .out_lane_slot(out_lane_slot)
);

// File: tb/dcu_top_tb_top.sv
module dcu_top_tb_top;
    localparam int LANES    = 8;
    localparam int CLK_HALF = 5;
    localparam int WDOG     = 20000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [31:0]         in_instr = '0;
    logic [LANES*32-1:0] in_vec = '0;
    logic [LANES-1:0]    in_mask = '0;
    logic                out_valid;
    logic [LANES*32-1:0] out_data, out_first_lane, out_lane_slot;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    done     = 0;
    string test_tag = "R11 reset";

    logic        exp_valid;
    logic [31:0] exp_data [LANES];
    logic [31:0] exp_first[LANES];
    logic [31:0] exp_slot [LANES];
    string       exp_data_tag = "R11";

    always #CLK_HALF clk = ~clk;

    dcu_top #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_vec(in_vec), .in_mask(in_mask), .out_valid(out_valid),
        .out_data(out_data), .out_first_lane(out_first_lane), .out_lane_slot(out_lane_slot)
    );

    function automatic logic [31:0] f32_of(input int c);
        logic [63:0] d;
        int          e;
        if (c == 0) return 32'd0;
        d = $realtobits(real'(c));
        e = int'(d[62:52]) - 1023 + 127;
        return {1'b0, e[7:0], d[51:29]};
    endfunction

    // Reference model, updated at each rising edge.
    always @(posedge clk) begin
        logic [31:0] seen_q[$];
        int          firstl_q[$];
        logic [31:0] lv [LANES];
        logic [31:0] nd [LANES];
        logic [31:0] nf [LANES];
        logic [31:0] ns [LANES];
        int          opc, c, idx;
        opc = int'(in_instr[21:16]);
        if (!rst_n) begin
            exp_valid <= 1'b0;
            for (int k = 0; k < LANES; k++) begin
                exp_data[k] <= '0; exp_first[k] <= '0; exp_slot[k] <= '0;
            end
        end else if (in_valid && opc >= 24 && opc <= 27) begin
            seen_q.delete(); firstl_q.delete();
            for (int k = 0; k < LANES; k++) lv[k] = in_vec[32*k +: 32];
            for (int k = 0; k < LANES; k++) begin
                ns[k] = 0;
                if (in_mask[k]) begin
                    idx = -1;
                    foreach (seen_q[i]) if (idx < 0 && seen_q[i] == lv[k]) idx = i;
                    if (idx < 0) begin
                        seen_q.push_back(lv[k]); firstl_q.push_back(k);
                        idx = seen_q.size() - 1;
                    end
                    ns[k] = 32'(idx);
                end
            end
            for (int s = 0; s < LANES; s++) begin
                nf[s] = (s < seen_q.size()) ? 32'(firstl_q[s]) : 32'd0;
            end
            for (int k = 0; k < LANES; k++) begin
                c = 0;
                if (in_mask[k])
                    for (int j = 0; j < LANES; j++) if (in_mask[j] && lv[j] == lv[k]) c++;
                if (opc >= 26)       nd[k] = (k < seen_q.size()) ? seen_q[k] : 32'd0;
                else if (opc == 25)  nd[k] = f32_of(c);
                else                 nd[k] = 32'(c);
            end
            exp_valid    <= 1'b1;
            exp_data_tag <= (opc == 24) ? "R3" : (opc == 25) ? "R4" : "R8";
            for (int k = 0; k < LANES; k++) begin
                exp_data[k] <= nd[k]; exp_first[k] <= nf[k]; exp_slot[k] <= ns[k];
            end
        end else begin
            exp_valid <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%h expected=%h t=%0t", tag, test_tag, act, expv, $time);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(out_valid == exp_valid, "R2 valid", 32'(out_valid), 32'(exp_valid));
            for (int k = 0; k < LANES; k++) begin
                chk(out_data[32*k +: 32] == exp_data[k], exp_data_tag, out_data[32*k +: 32], exp_data[k]);
                chk(out_first_lane[32*k +: 32] == exp_first[k], "R9 first lane", out_first_lane[32*k +: 32], exp_first[k]);
                chk(out_lane_slot[32*k +: 32] == exp_slot[k], "R7 lane slot", out_lane_slot[32*k +: 32], exp_slot[k]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send(input int opc, input logic [31:0] v [LANES], input logic [LANES-1:0] m);
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = {$urandom_range(0, 1023) & 32'h3ff, 6'(opc), 16'($urandom_range(0, 65535))};
        for (int k = 0; k < LANES; k++) in_vec[32*k +: 32] = v[k];
        in_mask = m;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_vec   = {LANES{32'hdead_beef}};
        end
    endtask

    initial begin
        logic [31:0] v [LANES];
        idle(3);
        rst_n = 1'b1;
        idle(2);

        test_tag = "R3 distinct";
        for (int k = 0; k < LANES; k++) v[k] = 32'(100 + k);
        send(24, v, '1); idle(1);

        test_tag = "R3 all equal";
        for (int k = 0; k < LANES; k++) v[k] = 32'd7;
        send(24, v, '1); send(26, v, '1); idle(1);

        test_tag = "R10 mixed repeats";
        v = '{32'd5, 32'd3, 32'd5, 32'd7, 32'd3, 32'd5, 32'd9, 32'd7};
        send(24, v, '1); send(26, v, '1); send(25, v, '1); send(27, v, '1); idle(1);

        test_tag = "R6 hidden copies";
        v = '{32'd5, 32'd3, 32'd5, 32'd7, 32'd3, 32'd5, 32'd9, 32'd7};
        send(24, v, 8'b1011_0110); send(26, v, 8'b1011_0110); send(25, v, 8'b0000_0001); idle(1);

        test_tag = "R6 empty mask";
        send(24, v, 8'h00); send(26, v, 8'h00); idle(1);

        test_tag = "R5 signed zero and NaN";
        v = '{32'h0000_0000, 32'h8000_0000, 32'h7fc0_0000, 32'h7fc0_0000,
              32'h7fc0_0001, 32'h8000_0000, 32'h3f80_0000, 32'h0000_0000};
        send(25, v, '1); send(27, v, '1); idle(1);

        test_tag = "R1 illegal opcodes";
        send(23, v, '1); send(28, v, '1); send(63, v, '1); send(0, v, '1); idle(2);

        test_tag = "R1 R2 random stream";
        for (int n = 0; n < 400; n++) begin
            logic [LANES-1:0] m;
            int               opc;
            for (int k = 0; k < LANES; k++) v[k] = 32'($urandom_range(0, 3)) << 30;
            m   = LANES'($urandom_range(0, 255));
            opc = ($urandom_range(0, 9) == 0) ? int'($urandom_range(28, 40)) : int'($urandom_range(24, 27));
            if ($urandom_range(0, 4) == 0) idle(1);
            else send(opc, v, m);
        end
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule